// File: doc/BRIEF.md
# Runtime-Bounded Response Latency Monitor

This block watches a trigger line and a response line on one clock and checks that every falling edge of the trigger is answered by the response within a limit. The limit is given as a number of clock cycles on a `bound` input. The block samples `bound` in the cycle of the falling edge, so each trigger can carry its own limit.

Each accepted trigger takes one of a fixed number of check slots. A slot counts down and retires on the first response cycle inside its window. If the response does not come in time, the slot retires with a failure pulse. Any number of slots can be open at once, and they run independently. Per-slot pass and fail pulses, saturating event counters, an overflow pulse for triggers that find no free slot, and a sticky error flag are brought out to the ports. A user places the block beside the logic it observes and reads the flags or counters.

Top module: `latency_watch`

## Requirements
- R1: A check starts only in a cycle where `trig` is 0 and was 1 in the previous cycle. A rising edge or a held level starts nothing. After reset the stored previous value is 0, so the first cycle cannot start a check.
- R2: Observation of `resp` begins in the cycle after the trigger's falling edge. The window lasts `bound`+1 cycles, so `bound`=0 allows only that first cycle.
- R3: The first window cycle with `resp`=1 retires the slot. Its bit in `pass_slot` is 1 for exactly one cycle: the cycle after that response cycle.
- R4: Once a slot has retired, further `resp` cycles for that trigger produce no pass and no fail.
- R5: If `resp` stays 0 for the whole window, the slot's bit in `fail_slot` is 1 for one cycle. That cycle comes right after the window's last cycle, which is `bound`+2 cycles after the falling-edge cycle.
- R6: A new trigger takes the lowest-numbered slot that is not open at the start of that cycle (bit i of `pass_slot`/`fail_slot` is slot i). Slots already open are not disturbed.
- R7: One `resp` cycle satisfies every open slot at once, and each of them gives its own pass pulse.
- R8: A trigger that finds every slot open is dropped. `overflow` is then 1 for one cycle, in the next cycle, and `ovf_count` goes up by one.
- R9: `pass_count`, `fail_count` and `ovf_count` add one for each pass, fail or overflow event. Each stops at its all-ones value.
- R10: `err_sticky` is set by the first failure and stays set until `clear_err` or reset. A failure in the same cycle as `clear_err` wins.
- R11: During and right after synchronous reset, all outputs are 0 and no slot is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear_err | input | 1 | Clears the sticky error flag |
| trig | input | 1 | Trigger; its falling edge opens a check |
| resp | input | 1 | Response being waited for |
| bound | input | DW | Window length minus one, sampled at the falling edge |
| pass_slot | output | NSLOT | Per-slot pass pulse |
| fail_slot | output | NSLOT | Per-slot fail pulse |
| overflow | output | 1 | Pulse: trigger dropped, all slots open |
| err_sticky | output | 1 | Set on any failure |
| pass_count | output | CW | Saturating pass count |
| fail_count | output | CW | Saturating fail count |
| ovf_count | output | CW | Saturating overflow count |

## Verification
A slot whose countdown value is off by one moves its fail pulse one cycle early or late. The bench sweeps every bound and response offset in a small range, so a shift like that shows up at once. A slot whose open bit is lost or stuck shows up within one window: a pass or fail pulse goes missing, an extra one appears, or `overflow` fires early when the slots are filled. A wrong edge history starts a check from a rising edge, and the resulting fail pulse appears `bound`+2 cycles later.

// File: rtl/latency_watch.sv
module latency_watch #(
  parameter int NSLOT = 4,
  parameter int DW    = 16,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_err,
  input  logic             trig,
  input  logic             resp,
  input  logic [DW-1:0]    bound,
  output logic [NSLOT-1:0] pass_slot,
  output logic [NSLOT-1:0] fail_slot,
  output logic             overflow,
  output logic             err_sticky,
  output logic [CW-1:0]    pass_count,
  output logic [CW-1:0]    fail_count,
  output logic [CW-1:0]    ovf_count
);

  localparam int SW = $clog2(NSLOT + 1);

  logic             trig_q;
  logic [NSLOT-1:0] open_q;
  logic [DW-1:0]    left_q [NSLOT];
  logic [NSLOT-1:0] hit, expire, grant;

  wire fall = trig_q & ~trig;

  function automatic logic [CW-1:0] sat_add(input logic [CW-1:0] a, input logic [SW-1:0] n);
    logic [CW:0] s;
    s = {1'b0, a} + (CW+1)'(n);
    return s[CW] ? '1 : s[CW-1:0];
  endfunction

  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < NSLOT; i++) begin
      hit[i]    = open_q[i] & resp;
      expire[i] = open_q[i] & ~resp & (left_q[i] == '0);
      if (fall && !open_q[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  wire drop = fall & (grant == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= 1'b0;
      open_q <= '0;
      for (int i = 0; i < NSLOT; i++) left_q[i] <= '0;
    end else begin
      trig_q <= trig;
      for (int i = 0; i < NSLOT; i++) begin
        if (grant[i]) begin
          open_q[i] <= 1'b1;
          left_q[i] <= bound;
        end else if (hit[i] || expire[i]) begin
          open_q[i] <= 1'b0;
        end else if (open_q[i]) begin
          left_q[i] <= left_q[i] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_slot  <= '0;
      fail_slot  <= '0;
      overflow   <= 1'b0;
      err_sticky <= 1'b0;
      pass_count <= '0;
      fail_count <= '0;
      ovf_count  <= '0;
    end else begin
      pass_slot  <= hit;
      fail_slot  <= expire;
      overflow   <= drop;
      pass_count <= sat_add(pass_count, SW'($countones(hit)));
      fail_count <= sat_add(fail_count, SW'($countones(expire)));
      ovf_count  <= sat_add(ovf_count, SW'(drop));
      if (expire != '0)   err_sticky <= 1'b1;
      else if (clear_err) err_sticky <= 1'b0;
    end
  end

  a_r3_pass_fail_exclusive: assert property (@(posedge clk) disable iff (rst)
    (pass_slot & fail_slot) == '0);

  a_r5_fail_needs_open: assert property (@(posedge clk) disable iff (rst)
    (open_q != '0) || (fail_slot == '0) |=> (fail_slot & ~$past(open_q)) == '0);

  a_r6_grant_takes_slot: assert property (@(posedge clk) disable iff (rst)
    (fall && open_q != '1) |=> $countones(open_q) >= 1);

  a_r8_overflow_only_full: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $past(open_q) == '1 && $past(fall));

  a_r9_counts_monotonic: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pass_count >= $past(pass_count) && fail_count >= $past(fail_count)
             && ovf_count >= $past(ovf_count));

  a_r10_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    (err_sticky && !clear_err) |=> err_sticky);

  a_r10_set_on_fail: assert property (@(posedge clk) disable iff (rst)
    (fail_slot != '0) |-> err_sticky);

endmodule

// File: tb/latency_watch_test.sv
module latency_watch_test;
  localparam int NS = 4;
  localparam int CW = 4;
  localparam int CMAX = 15;

  logic clk = 0, rst = 1, clear_err = 0, trig = 0, resp = 0;
  logic [15:0] bound = 0;
  logic [NS-1:0] pass_slot, fail_slot;
  logic overflow, err_sticky;
  logic [CW-1:0] pass_count, fail_count, ovf_count;

  int checks = 0, failures = 0;
  int n_pass = 0, n_fail = 0;
  bit done = 0;

  latency_watch #(.NSLOT(NS), .DW(16), .CW(CW)) uut (
    .clk(clk), .rst(rst), .clear_err(clear_err), .trig(trig), .resp(resp), .bound(bound),
    .pass_slot(pass_slot), .fail_slot(fail_slot), .overflow(overflow), .err_sticky(err_sticky),
    .pass_count(pass_count), .fail_count(fail_count), .ovf_count(ovf_count));

  always #10 clk = ~clk;

  function automatic int sat(input int v);
    return v > CMAX ? CMAX : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic t, input logic r, input logic [15:0] b, input logic c);
    @(negedge clk);
    trig = t; resp = r; bound = b; clear_err = c;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; trig = 0; resp = 0; clear_err = 0;
    @(posedge clk); @(posedge clk); #1;
    @(negedge clk); rst = 0;
    n_pass = 0; n_fail = 0;
  endtask

  task automatic run_single(input int b, input int d, input bit extra);
    tick(1, 0, 0, 0);
    tick(0, 0, 16'(b), 0);
    for (int k = 0; k <= b + 1; k++) begin
      tick(0, extra ? (k >= d) : (k == d), 0, 0);
      chk(extra ? "R4 pass_slot" : "R2/R3 pass_slot", pass_slot, (k == d && d <= b) ? 1 : 0);
      chk("R5 fail_slot", fail_slot, (k == b && d > b) ? 1 : 0);
    end
    if (d <= b) n_pass++; else n_fail++;
    chk("R9 pass_count", pass_count, sat(n_pass));
    chk("R9 fail_count", fail_count, sat(n_fail));
    chk("R10 err_sticky", err_sticky, n_fail > 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11 reset state with activity on the inputs
    @(negedge clk); trig = 1; resp = 1;
    @(posedge clk); #1;
    @(negedge clk); trig = 0;
    @(posedge clk); #1;
    chk("R11 pass_slot", pass_slot, 0);
    chk("R11 fail_slot", fail_slot, 0);
    chk("R11 counts", pass_count + fail_count + ovf_count, 0);
    chk("R11 err_sticky", err_sticky, 0);
    @(negedge clk); rst = 0; resp = 0;
    for (int k = 0; k < 3; k++) begin
      tick(0, 0, 0, 0);
      chk("R1 R11 no check after reset", fail_slot | pass_slot, 0);
    end

    // R1 rising edge and held level start nothing
    tick(1, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      tick(1, 0, 0, 0);
      chk("R1 no check on high level", fail_slot, 0);
    end
    tick(0, 0, 0, 0);
    tick(0, 1, 0, 0);
    chk("R1 fall starts check", pass_slot, 1);

    // R2 R3 R4 R5 R9 R10 sweep
    do_reset();
    for (int b = 0; b <= 5; b++)
      for (int d = 0; d <= 7; d++)
        for (int e = 0; e < 2; e++)
          run_single(b, d, e[0]);
    chk("R9 fail_count saturated", fail_count, CMAX);

    // R10 clear, and failure wins over clear
    tick(0, 0, 0, 1);
    chk("R10 cleared", err_sticky, 0);
    tick(1, 0, 0, 0);
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 1);
    chk("R10 fail beats clear", err_sticky, 1);
    chk("R5 fail with clear", fail_slot, 1);

    // R6 independent concurrent slots
    do_reset();
    tick(1, 0, 0, 0);
    tick(0, 0, 6, 0);
    for (int k = 1; k <= 8; k++) begin
      tick(k == 1, 0, (k == 2) ? 16'd1 : 16'd0, 0);
      chk("R6 fail_slot", fail_slot, (k == 4) ? 2 : (k == 7) ? 1 : 0);
    end

    // R7 one response satisfies all open slots
    do_reset();
    for (int j = 0; j < 3; j++) begin
      tick(1, 0, 0, 0);
      tick(0, 0, 10, 0);
    end
    tick(0, 1, 0, 0);
    chk("R7 pass_slot", pass_slot, 7);
    chk("R7 pass_count", pass_count, 3);
    tick(0, 1, 0, 0);
    chk("R4 extra resp ignored", pass_slot | fail_slot, 0);

    // R8 overflow when all slots open
    do_reset();
    for (int j = 0; j < 5; j++) begin
      tick(1, 0, 0, 0);
      tick(0, 0, 20, 0);
      chk("R8 overflow", overflow, j == 4);
    end
    chk("R8 ovf_count", ovf_count, 1);
    tick(0, 0, 0, 0);
    chk("R8 overflow one cycle", overflow, 0);
    tick(0, 1, 0, 0);
    chk("R8 dropped trigger untracked", pass_slot, 15);
    for (int k = 0; k < 25; k++) begin
      tick(0, 0, 0, 0);
      chk("R8 no late fail", fail_slot, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule